// File: doc/BRIEF.md
# Pin Interrupt Edge Detector

This block turns activity on external pins into interrupt requests for a small controller. It watches sixteen general pins, split into two ports of eight, and one non-maskable pin. Every pin first passes through a two-flop synchronizer and then a glitch filter. The filter only takes a new level once three consecutive synchronized samples agree. An edge detector follows the filter and fires on the rising or the falling edge, as the pin's polarity bit selects.

All enabled pins of one port feed a single shared request. The block therefore gives one request line for each port plus one for the non-maskable pin. Each request is a one-cycle pulse meant for the controller's pending latch. Software finds which pin fired by reading the filtered level outputs of the port. Changing the polarity of an enabled source raises a request by itself. The non-maskable source only takes part while its pin is switched to its alternate function. The enable and polarity settings arrive as inputs from registers held elsewhere.

Top module: `pin_irq_edge`

## Requirements
- R1: `pa_level[i]` and `pb_level[i]` report the filtered level of `pa_pins[i]` and `pb_pins[i]`, bit i for pin i, so that software can tell which pin of a port fired.
- R2: A steady change on a pin shows on its level output just after the fifth rising clock edge, counting the first edge at which the new pin value is sampled.
- R3: The filter takes a new level only after three consecutive synchronized samples agree. A pulse lasting one or two clock cycles leaves the level and the requests unchanged, and a pulse lasting three cycles is accepted.
- R4: Polarity bit 0 selects the rising edge of the filtered level and bit 1 selects the falling edge. The opposite edge raises no request.
- R5: When the filtered level of an enabled pin makes its selected edge, the port's request is high for exactly one cycle, starting at the clock edge after the level output changes.
- R6: A pin whose enable bit is 0 contributes nothing to its port's request, whether through edges or polarity changes, yet its level output still follows the pin.
- R7: Changing the polarity bit of an enabled source raises that source's request at the next clock edge, for one cycle, even when the pin is idle.
- R8: The non-maskable pin has the same filter, edge and polarity rules and its own request `nmi_req`. It raises requests only while `nmi_alt_en` is 1, and the port enables do not affect it.
- R9: A synchronous active-high reset clears all requests, all level outputs and the synchronizer and filter history.
- R10: Selected edges on several enabled pins of one port in the same cycle give a single one-cycle request on that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_alt_en | input | 1 | 1 when the non-maskable pin is in its alternate function |
| nmi_pol | input | 1 | Edge polarity of the non-maskable pin (0 rising, 1 falling) |
| pa_pins | input | 8 | Port A pins |
| pb_pins | input | 8 | Port B pins |
| pa_en | input | 8 | Port A per-pin interrupt enable |
| pb_en | input | 8 | Port B per-pin interrupt enable |
| pa_pol | input | 8 | Port A per-pin polarity (0 rising, 1 falling) |
| pb_pol | input | 8 | Port B per-pin polarity (0 rising, 1 falling) |
| nmi_req | output | 1 | One-cycle non-maskable request |
| pa_req | output | 1 | One-cycle shared request of port A |
| pb_req | output | 1 | One-cycle shared request of port B |
| pa_level | output | 8 | Filtered levels of port A pins |
| pb_level | output | 8 | Filtered levels of port B pins |

## Verification
Random pin toggling with a one-in-eight chance per pin per cycle produces a mix of short glitches and held levels. Each cycle, both outputs are compared against a latency model, which shows whether the three-sample agreement window holds and whether edges land on the right cycle. Random changes of enable and polarity in the same run show apart edge-triggered requests, polarity-triggered requests and masked pins. Directed cases separate two-cycle from three-cycle pulses, the exact five-edge level latency, simultaneous edges inside one port, and the non-maskable pin with its alternate function on and off.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int PORT_W      = 8;
    localparam int NUM_PORTS   = 2;
    localparam int SYNC_STAGES = 2;
    localparam int FILT_DEPTH  = 3;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } pol_e;

    typedef struct packed {
        logic edge_hit;
        logic pol_flip;
    } src_evt_t;

    function automatic logic edge_seen(logic prev, logic cur, pol_e pol);
        if (pol == POL_FALL) begin
            return prev & ~cur;
        end
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/pirq_sync_filter.sv
module pirq_sync_filter
    import pirq_pkg::*;
#(
    parameter int W       = PORT_W,
    parameter int SYNC_N  = SYNC_STAGES,
    parameter int AGREE_N = FILT_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level
);

    localparam int HIST_N = AGREE_N - 1;

    logic [W-1:0] sync_q [SYNC_N];
    logic [W-1:0] hist_q [HIST_N];
    logic [W-1:0] sync_last;
    logic [W-1:0] hist_last;
    logic [W-1:0] all_hi;
    logic [W-1:0] all_lo;
    logic [W-1:0] level_q;

    // synchronizer chain
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_N; i++) begin
                sync_q[i] <= '0;
            end
        end else begin
            sync_q[0] <= raw;
            for (int i = 1; i < SYNC_N; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign sync_last = sync_q[SYNC_N-1];

    // sample history behind the synchronizer
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST_N; i++) begin
                hist_q[i] <= '0;
            end
        end else begin
            hist_q[0] <= sync_last;
            for (int i = 1; i < HIST_N; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    assign hist_last = hist_q[HIST_N-1];

    // agreement across the whole window
    always_comb begin
        all_hi = sync_last;
        all_lo = ~sync_last;
        for (int i = 0; i < HIST_N; i++) begin
            all_hi = all_hi & hist_q[i];
            all_lo = all_lo & ~hist_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= all_hi | (level_q & ~all_lo);
        end
    end

    assign level = level_q;

    // R3: a bit only moves to a value that both the newest and the oldest sample held
    p_filter_agree_r3: assert property (@(posedge clk) disable iff (rst)
        (((level_q ^ $past(level_q)) & (level_q ^ $past(sync_last))) == '0) &&
        (((level_q ^ $past(level_q)) & (level_q ^ $past(hist_last))) == '0));

    // R9: reset clears the filtered level
    p_reset_level_r9: assert property (@(posedge clk)
        rst |=> (level_q == '0));

endmodule

// File: rtl/pirq_edge_unit.sv
module pirq_edge_unit
    import pirq_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] en,
    input  logic [W-1:0] pol,
    output logic         req
);

    logic [W-1:0]         level_d_q;
    logic [W-1:0]         pol_q;
    src_evt_t [W-1:0]     evt;
    logic                 hit;
    logic                 req_q;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < W; i++) begin
            evt[i].edge_hit = edge_seen(level_d_q[i], level[i], pol_e'(pol[i]));
            evt[i].pol_flip = pol[i] ^ pol_q[i];
            hit = hit | (en[i] & (evt[i].edge_hit | evt[i].pol_flip));
        end
    end

    // polarity copy follows even through reset, so leaving reset raises nothing
    always_ff @(posedge clk) begin
        pol_q <= pol;
        if (rst) begin
            level_d_q <= '0;
            req_q     <= 1'b0;
        end else begin
            level_d_q <= level;
            req_q     <= hit;
        end
    end

    assign req = req_q;

    // R6: a fully masked group stays silent
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !req_q);

    // R7: a polarity change on an enabled source raises a request
    p_pol_flip_req_r7: assert property (@(posedge clk) disable iff (rst)
        (|(en & (pol ^ $past(pol)))) |=> req_q);

    // R5: a selected edge on an enabled source raises a request
    p_edge_req_r5: assert property (@(posedge clk) disable iff (rst)
        (|(en & (level ^ $past(level)) & (level ^ pol))) |=> req_q);

    // R9: reset clears the request
    p_reset_req_r9: assert property (@(posedge clk)
        rst |=> !req_q);

endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge
    import pirq_pkg::*;
#(
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nmi_pin,
    input  logic          nmi_alt_en,
    input  logic          nmi_pol,
    input  logic [PW-1:0] pa_pins,
    input  logic [PW-1:0] pb_pins,
    input  logic [PW-1:0] pa_en,
    input  logic [PW-1:0] pb_en,
    input  logic [PW-1:0] pa_pol,
    input  logic [PW-1:0] pb_pol,
    output logic          nmi_req,
    output logic          pa_req,
    output logic          pb_req,
    output logic [PW-1:0] pa_level,
    output logic [PW-1:0] pb_level
);

    logic [PW-1:0] port_raw   [NUM_PORTS];
    logic [PW-1:0] port_en    [NUM_PORTS];
    logic [PW-1:0] port_pol   [NUM_PORTS];
    logic [PW-1:0] port_level [NUM_PORTS];
    logic          port_req   [NUM_PORTS];
    logic          nmi_level;

    assign port_raw[0] = pa_pins;
    assign port_raw[1] = pb_pins;
    assign port_en[0]  = pa_en;
    assign port_en[1]  = pb_en;
    assign port_pol[0] = pa_pol;
    assign port_pol[1] = pb_pol;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pirq_sync_filter #(
            .W       (PW),
            .SYNC_N  (SYNC_STAGES),
            .AGREE_N (FILT_DEPTH)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (port_raw[p]),
            .level (port_level[p])
        );

        pirq_edge_unit #(
            .W (PW)
        ) u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (port_level[p]),
            .en    (port_en[p]),
            .pol   (port_pol[p]),
            .req   (port_req[p])
        );
    end

    pirq_sync_filter #(
        .W       (1),
        .SYNC_N  (SYNC_STAGES),
        .AGREE_N (FILT_DEPTH)
    ) u_nmi_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   (nmi_pin),
        .level (nmi_level)
    );

    pirq_edge_unit #(
        .W (1)
    ) u_nmi_edge (
        .clk   (clk),
        .rst   (rst),
        .level (nmi_level),
        .en    (nmi_alt_en),
        .pol   (nmi_pol),
        .req   (nmi_req)
    );

    assign pa_level = port_level[0];
    assign pb_level = port_level[1];
    assign pa_req   = port_req[0];
    assign pb_req   = port_req[1];

    // R8: outside its alternate function the non-maskable pin stays quiet
    p_nmi_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !nmi_alt_en |=> !nmi_req);

    // R6: port requests need at least one enabled pin
    p_port_masked_r6: assert property (@(posedge clk) disable iff (rst)
        ((pa_en == '0) && (pb_en == '0)) |=> (!pa_req && !pb_req));

endmodule

// File: tb/pin_irq_edge_bench.sv
module pin_irq_edge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 17;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nmi_pin = 1'b0, nmi_alt_en = 1'b0, nmi_pol = 1'b0;
    logic [7:0] pa_pins = '0, pb_pins = '0, pa_en = '0, pb_en = '0;
    logic [7:0] pa_pol = '0, pb_pol = '0;
    logic       nmi_req, pa_req, pb_req;
    logic [7:0] pa_level, pb_level;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_edge u_pin_irq_edge (
        .clk        (clk),
        .rst        (rst),
        .nmi_pin    (nmi_pin),
        .nmi_alt_en (nmi_alt_en),
        .nmi_pol    (nmi_pol),
        .pa_pins    (pa_pins),
        .pb_pins    (pb_pins),
        .pa_en      (pa_en),
        .pb_en      (pb_en),
        .pa_pol     (pa_pol),
        .pb_pol     (pb_pol),
        .nmi_req    (nmi_req),
        .pa_req     (pa_req),
        .pb_req     (pb_req),
        .pa_level   (pa_level),
        .pb_level   (pb_level)
    );

    // ---------------- reference model from the requirements ----------------
    logic [NS-1:0] rs [5];
    logic [NS-1:0] lvl1, lvl2, polp;
    logic          exp_pa, exp_pb, exp_nmi;

    // R2/R3: level after an edge is the sample two edges old, once it and the two before it agree
    function automatic logic [NS-1:0] next_level(logic [NS-1:0] s2, logic [NS-1:0] s3,
                                                 logic [NS-1:0] s4, logic [NS-1:0] cur);
        logic [NS-1:0] agree;
        agree = ~(s2 ^ s3) & ~(s3 ^ s4);
        return (agree & s2) | (~agree & cur);
    endfunction

    // R4/R5/R7: selected edge of the level, or polarity change, on an enabled source
    function automatic logic [NS-1:0] hit_vec(logic [NS-1:0] l1, logic [NS-1:0] l2,
                                              logic [NS-1:0] p, logic [NS-1:0] pp,
                                              logic [NS-1:0] e);
        return e & (((l1 ^ l2) & (l1 ^ p)) | (p ^ pp));
    endfunction

    always @(posedge clk) begin
        logic [NS-1:0] hv;
        logic [NS-1:0] nl;
        if (rst) begin
            for (int i = 0; i < 5; i++) rs[i] = '0;
            lvl1 = '0; lvl2 = '0;
            exp_pa = 1'b0; exp_pb = 1'b0; exp_nmi = 1'b0;
        end else begin
            for (int i = 4; i > 0; i--) rs[i] = rs[i-1];
            rs[0] = {nmi_pin, pb_pins, pa_pins};
            hv = hit_vec(lvl1, lvl2, {nmi_pol, pb_pol, pa_pol}, polp,
                         {nmi_alt_en, pb_en, pa_en});
            exp_pa  = |hv[7:0];
            exp_pb  = |hv[15:8];
            exp_nmi = hv[16];
            nl   = next_level(rs[2], rs[3], rs[4], lvl1);
            lvl2 = lvl1;
            lvl1 = nl;
        end
        polp = {nmi_pol, pb_pol, pa_pol};
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(pa_level == lvl1[7:0],  "R1 R2 port A level", pa_level, lvl1[7:0]);
            check(pb_level == lvl1[15:8], "R1 R2 port B level", pb_level, lvl1[15:8]);
            check(pa_req == exp_pa,   "R5 port A request", pa_req, exp_pa);
            check(pb_req == exp_pb,   "R5 port B request", pb_req, exp_pb);
            check(nmi_req == exp_nmi, "R8 nmi request", nmi_req, exp_nmi);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_pulses(input int n, output int ca, output int cb, output int cn);
        ca = 0; cb = 0; cn = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pa_req)  ca++;
            if (pb_req)  cb++;
            if (nmi_req) cn++;
        end
    endtask

    initial begin
        int ca, cb, cn;
        void'($urandom(32'd20240611));

        // ---------------- reset ----------------
        idle(4);
        @(negedge clk);
        check(pa_level == 8'h00 && pb_level == 8'h00, "R9 levels after reset",
              {pa_level, pb_level}, 16'h0);
        check({pa_req, pb_req, nmi_req} == 3'b000, "R9 requests after reset",
              {pa_req, pb_req, nmi_req}, 3'b000);
        rst = 1'b0;
        idle(2);

        // ---------------- random phase ----------------
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            pa_pins = pa_pins ^ 8'($urandom & $urandom & $urandom);
            pb_pins = pb_pins ^ 8'($urandom & $urandom & $urandom);
            if (($urandom % 8) == 0) nmi_pin = ~nmi_pin;
            if ((c % 37) == 0) begin
                pa_en = 8'($urandom);
                pb_en = 8'($urandom);
                nmi_alt_en = 1'($urandom);
            end
            if ((c % 53) == 0) begin
                pa_pol = pa_pol ^ 8'($urandom & $urandom);
                pb_pol = pb_pol ^ 8'($urandom & $urandom);
                nmi_pol = 1'($urandom);
            end
        end

        // ---------------- quiet state ----------------
        @(negedge clk);
        pa_en = '0; pb_en = '0; nmi_alt_en = 1'b0;
        pa_pol = '0; pb_pol = '0; nmi_pol = 1'b0;
        pa_pins = '0; pb_pins = '0; nmi_pin = 1'b0;
        idle(12);
        pa_en = 8'b0000_1111;
        pb_en = 8'b0000_0100;
        idle(3);

        // R3: two-cycle pulse is filtered away
        pa_pins[0] = 1'b1; idle(2); pa_pins[0] = 1'b0;
        count_pulses(15, ca, cb, cn);
        check(ca == 0, "R3 two-cycle glitch ignored", ca, 0);
        check(pa_level == 8'h00, "R3 level unchanged by glitch", pa_level, 0);

        // R3/R4: three-cycle pulse accepted, rising edge only
        pa_pins[0] = 1'b1; idle(3); pa_pins[0] = 1'b0;
        count_pulses(15, ca, cb, cn);
        check(ca == 1, "R3 R4 three-cycle pulse gives one rising request", ca, 1);

        // R2/R5: exact latency of level and request
        pa_pins[3] = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k < 5) check(pa_level[3] == 1'b0, "R2 level not yet changed", pa_level[3], 0);
            if (k == 5) begin
                check(pa_level[3] == 1'b1, "R2 level after fifth edge", pa_level[3], 1);
                check(pa_req == 1'b0, "R5 request not before level", pa_req, 0);
            end
            if (k == 6) check(pa_req == 1'b1, "R5 request one edge after level", pa_req, 1);
        end
        @(negedge clk);
        check(pa_req == 1'b0, "R5 request lasts one cycle", pa_req, 0);
        pa_pins[3] = 1'b0;
        idle(10);

        // R10: two pins of one port rise together
        pa_pins[1] = 1'b1; pa_pins[2] = 1'b1;
        count_pulses(20, ca, cb, cn);
        check(ca == 1, "R10 simultaneous edges merge", ca, 1);
        pa_pins[1] = 1'b0; pa_pins[2] = 1'b0;
        idle(10);

        // R4: falling polarity ignores rising edge, takes falling edge
        pa_pol[0] = 1'b1;
        count_pulses(4, ca, cb, cn);
        check(ca == 1, "R7 polarity change on enabled pin", ca, 1);
        pa_pins[0] = 1'b1;
        count_pulses(12, ca, cb, cn);
        check(ca == 0, "R4 rising edge ignored on falling polarity", ca, 0);
        pa_pins[0] = 1'b0;
        count_pulses(12, ca, cb, cn);
        check(ca == 1, "R4 falling edge accepted", ca, 1);

        // R6: disabled pin moves its level but raises nothing
        pb_pins[5] = 1'b1;
        idle(7);
        check(pb_level[5] == 1'b1, "R1 R6 disabled pin level follows", pb_level[5], 1);
        pb_pins[5] = 1'b0;
        count_pulses(12, ca, cb, cn);
        check(cb == 0, "R6 disabled pin edges silent", cb, 0);
        pb_pol[6] = 1'b1;
        count_pulses(4, ca, cb, cn);
        check(cb == 0, "R6 disabled pin polarity change silent", cb, 0);

        // R7: polarity change on enabled idle pin
        pb_pol[2] = 1'b1;
        @(negedge clk);
        check(pb_req == 1'b1, "R7 polarity change request next edge", pb_req, 1);
        @(negedge clk);
        check(pb_req == 1'b0, "R7 polarity request one cycle", pb_req, 0);
        idle(4);

        // R8: non-maskable pin gated by alternate function
        nmi_pol = 1'b1;
        idle(3);
        nmi_pin = 1'b1; idle(6); nmi_pin = 1'b0;
        count_pulses(15, ca, cb, cn);
        check(cn == 0, "R8 nmi silent without alternate function", cn, 0);
        pa_en = '0; pb_en = '0;
        nmi_alt_en = 1'b1;
        idle(3);
        nmi_pin = 1'b1; idle(6); nmi_pin = 1'b0;
        count_pulses(15, ca, cb, cn);
        check(cn == 1, "R8 nmi falling edge with port enables off", cn, 1);
        nmi_pol = 1'b0;
        count_pulses(4, ca, cb, cn);
        check(cn == 1, "R7 R8 nmi polarity change request", cn, 1);
        idle(5);

        // R9: reset in mid-activity clears everything
        pa_pins = 8'hFF;
        idle(8);
        rst = 1'b1;
        idle(2);
        check(pa_level == 8'h00, "R9 reset clears levels", pa_level, 0);
        check({pa_req, pb_req, nmi_req} == 3'b000, "R9 reset clears requests",
              {pa_req, pb_req, nmi_req}, 0);
        pa_pins = 8'h00;
        rst = 1'b0;
        idle(10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule